// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

A 16-bit down-counter for interval timing and periodic interrupts. Software writes a start value through a simple write strobe. The value appears on the count output at once and is also kept in a reload latch. From then on the counter steps down by one on each enabled tick of the chosen timing source. The first enabled tick after any write only arms the counter, so one full tick period passes before the first decrement.

Ticks are single-cycle enable pulses in the system clock domain. A select input picks between a fast and a slow tick. A second select swaps a divide-by-26 tick in for the fast one. While the standby input is high, no tick is accepted.

An enabled tick that finds the count at zero is an underflow. In free-running mode the count then wraps to all ones. In prescale mode it reloads the last written value. Either way a sticky interrupt flag is set, and it stays set until an end-of-interrupt strobe clears it. The count and the mode can be read at any time without disturbing counting.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, count_o is 0, irq_o is 0 and mode_o is 0 (free-running).
- R2: A cycle with wr_load_i high makes count_o equal wr_data_i from the next cycle on, and stores wr_data_i as the reload value.
- R3: The first enabled tick after a write leaves the count unchanged. Each later enabled tick lowers it by one. A write in the same cycle as a tick takes precedence, and that tick is discarded.
- R4: With mode_o = 0, an enabled tick at count 0 sets the count to 0xFFFF.
- R5: With mode_o = 1, an enabled tick at count 0 sets the count to the last written value.
- R6: An underflow sets irq_o in the next cycle. irq_o then stays high until a cycle with eoi_i high. If eoi_i coincides with an underflow, irq_o stays set.
- R7: With tick_sel_i = 1, only slow_tick_i counts. With tick_sel_i = 0, fast_tick_i counts when div26_sel_i = 0, and div26_tick_i counts when div26_sel_i = 1. Ticks from sources that are not selected have no effect on the count.
- R8: While standby_i is high, ticks are ignored: the count holds, and the pending first-tick arm is not used up.
- R9: In prescale mode with a written value of 0, each counting tick keeps the count at 0 and raises an underflow.
- R10: A cycle with cfg_we_i high sets mode_o to cfg_mode_i from the next cycle on (0 = free-running, 1 = prescale). A mode write does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_load_i | input | 1 | Write strobe for the load value |
| wr_data_i | input | 16 | Load value |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_mode_i | input | 1 | Mode to write: 0 free-running, 1 prescale |
| eoi_i | input | 1 | End-of-interrupt strobe that clears irq_o |
| fast_tick_i | input | 1 | Fast tick enable pulse |
| slow_tick_i | input | 1 | Slow tick enable pulse |
| div26_tick_i | input | 1 | Divide-by-26 tick enable pulse |
| tick_sel_i | input | 1 | 1 selects the slow tick, 0 selects the fast tick |
| div26_sel_i | input | 1 | 1 substitutes the divide-by-26 tick for the fast tick |
| standby_i | input | 1 | Freezes counting while high |
| count_o | output | 16 | Current count |
| mode_o | output | 1 | Current mode |
| irq_o | output | 1 | Sticky underflow interrupt |

## Verification
Every result is registered once. A write, a mode write, a tick or an end-of-interrupt strobe applied before a rising edge shows on count_o, mode_o or irq_o after that same edge. The underflow flag is therefore visible exactly one cycle after the tick that found zero. The bench drives inputs just after a falling edge and lets its behavioural model step on the rising edge. It compares count and flag at the following falling edge, so each expected value is sampled in the cycle it is due. Directed sequences with hand-placed ticks pin down the arm-then-decrement order, the coincidences of write with tick and of clear with underflow, and the behaviour of the unselected and standby tick paths.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic {
    MODE_FREE     = 1'b0,
    MODE_PRESCALE = 1'b1
  } tmr_mode_e;

  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } tmr_src_e;
endpackage

// File: rtl/timer_tick_mux.sv
module timer_tick_mux #(
  parameter bit HAS_DIV26 = 1'b1
) (
  input  logic fast_tick_i,
  input  logic slow_tick_i,
  input  logic div26_tick_i,
  input  logic tick_sel_i,
  input  logic div26_sel_i,
  input  logic standby_i,
  output logic tick_en_o
);
  import timer_pkg::*;

  logic fast_src;
  logic picked;

  generate
    if (HAS_DIV26) begin : g_div26
      assign fast_src = div26_sel_i ? div26_tick_i : fast_tick_i;
    end else begin : g_plain
      logic unused_div26;
      assign unused_div26 = div26_tick_i ^ div26_sel_i;
      assign fast_src = fast_tick_i;
    end
  endgenerate

  always_comb begin
    unique case (tmr_src_e'(tick_sel_i))
      SRC_SLOW: picked = slow_tick_i;
      default:  picked = fast_src;
    endcase
  end

  assign tick_en_o = picked & ~standby_i;
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             tick_en_i,
  input  logic             mode_i,
  output logic [WIDTH-1:0] count_o,
  output logic             skip_o,
  output logic             underflow_o
);
  import timer_pkg::*;

  localparam logic [WIDTH-1:0] WRAP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] reload_q;
  logic             skip_q, skip_d;
  logic             at_zero;
  logic             uf;

  assign at_zero = (cnt_q == '0);
  assign uf      = ~load_i & tick_en_i & ~skip_q & at_zero;

  always_comb begin
    cnt_d  = cnt_q;
    skip_d = skip_q;
    if (load_i) begin
      cnt_d  = load_val_i;
      skip_d = 1'b1;
    end else if (tick_en_i) begin
      if (skip_q) begin
        skip_d = 1'b0;
      end else if (at_zero) begin
        cnt_d = (tmr_mode_e'(mode_i) == MODE_PRESCALE) ? reload_q : WRAP_VAL;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      skip_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      skip_q <= skip_d;
      if (load_i) reload_q <= load_val_i;
    end
  end

  assign count_o     = cnt_q;
  assign skip_o      = skip_q;
  assign underflow_o = uf;
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;  // set beats clear
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int WIDTH     = 16,
  parameter bit HAS_DIV26 = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_load_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             cfg_we_i,
  input  logic             cfg_mode_i,
  input  logic             eoi_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic             div26_tick_i,
  input  logic             tick_sel_i,
  input  logic             div26_sel_i,
  input  logic             standby_i,
  output logic [WIDTH-1:0] count_o,
  output logic             mode_o,
  output logic             irq_o
);
  import timer_pkg::*;

  logic      tick_en;
  logic      skip_q;
  logic      underflow;
  tmr_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_FREE;
    else if (cfg_we_i) mode_q <= tmr_mode_e'(cfg_mode_i);
  end

  timer_tick_mux #(.HAS_DIV26(HAS_DIV26)) u_mux (
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .div26_tick_i(div26_tick_i),
    .tick_sel_i  (tick_sel_i),
    .div26_sel_i (div26_sel_i),
    .standby_i   (standby_i),
    .tick_en_o   (tick_en)
  );

  timer_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_load_i),
    .load_val_i (wr_data_i),
    .tick_en_i  (tick_en),
    .mode_i     (mode_q),
    .count_o    (count_o),
    .skip_o     (skip_q),
    .underflow_o(underflow)
  );

  timer_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (underflow),
    .clr_i (eoi_i),
    .irq_o (irq_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_load_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             cfg_we_i,
  input logic             cfg_mode_i,
  input logic             eoi_i,
  input logic             standby_i,
  input logic             tick_en,
  input logic             skip_q,
  input logic             underflow,
  input logic [WIDTH-1:0] count_o,
  input logic             mode_o,
  input logic             irq_o
);
  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load_i |=> count_o == $past(wr_data_i));

  // R3
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_load_i && tick_en && skip_q) |=> $stable(count_o));

  // R3
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_load_i && tick_en && !skip_q && count_o != '0)
      |=> count_o == WIDTH'($past(count_o) - WIDTH'(1)));

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_load_i && tick_en && !skip_q && count_o == '0 && !mode_o) |=> &count_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_load_i && !tick_en) |=> $stable(count_o));

  // R8
  standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> !tick_en);

  // R6
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow |=> irq_o);

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_i) |=> irq_o);

  // R6
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !underflow) |=> !irq_o);

  // R10
  mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> mode_o == $past(cfg_mode_i));
endmodule

bind dual_mode_timer timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_load_i (wr_load_i),
  .wr_data_i (wr_data_i),
  .cfg_we_i  (cfg_we_i),
  .cfg_mode_i(cfg_mode_i),
  .eoi_i     (eoi_i),
  .standby_i (standby_i),
  .tick_en   (tick_en),
  .skip_q    (skip_q),
  .underflow (underflow),
  .count_o   (count_o),
  .mode_o    (mode_o),
  .irq_o     (irq_o)
);

// File: tb/tb_dual_mode_timer.sv
module tb_dual_mode_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_load_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        cfg_we_i = 1'b0, cfg_mode_i = 1'b0, eoi_i = 1'b0;
  logic        fast_tick_i = 1'b0, slow_tick_i = 1'b0, div26_tick_i = 1'b0;
  logic        tick_sel_i = 1'b0, div26_sel_i = 1'b0, standby_i = 1'b0;
  logic [15:0] count_o;
  logic        mode_o, irq_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 0, m_rel = 0, m_skip = 0, m_irq = 0, m_mode = 0;

  always #2.5 clk_i = ~clk_i;

  dual_mode_timer dut (.*);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_rel = 0; m_skip = 0; m_irq = 0; m_mode = 0;
    end else begin
      int t, uf;
      t  = tick_sel_i ? slow_tick_i : (div26_sel_i ? div26_tick_i : fast_tick_i);
      t  = t & !standby_i;
      uf = 0;
      if (wr_load_i) begin
        m_cnt = wr_data_i; m_rel = wr_data_i; m_skip = 1;
      end else if (t != 0) begin
        if (m_skip != 0) m_skip = 0;
        else if (m_cnt == 0) begin
          uf = 1;
          m_cnt = (m_mode != 0) ? m_rel : 16'hFFFF;
        end else m_cnt = m_cnt - 1;
      end
      if (uf != 0) m_irq = 1;
      else if (eoi_i) m_irq = 0;
      if (cfg_we_i) m_mode = cfg_mode_i;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: let the edge pass, compare against the model
  task automatic step();
    @(negedge clk_i);
    cycles++;
    check("R2/R3/R4/R5 count vs model", int'(count_o), m_cnt);
    check("R6 irq vs model", int'(irq_o), m_irq);
    check("R10 mode vs model", int'(mode_o), m_mode);
    wr_load_i = 0; cfg_we_i = 0; eoi_i = 0;
    fast_tick_i = 0; slow_tick_i = 0; div26_tick_i = 0;
  endtask

  task automatic wr(input int v);
    wr_load_i = 1; wr_data_i = 16'(v); step();
  endtask

  task automatic set_mode(input bit m);
    cfg_we_i = 1; cfg_mode_i = m; step();
  endtask

  task automatic tick();
    if (tick_sel_i) slow_tick_i = 1;
    else if (div26_sel_i) div26_tick_i = 1;
    else fast_tick_i = 1;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset count", int'(count_o), 0);
    check("R1 reset irq", int'(irq_o), 0);
    check("R1 reset mode", int'(mode_o), 0);

    // R2 / R3 arm then decrement
    wr(10);
    check("R2 loaded", int'(count_o), 10);
    tick(); check("R3 first tick arms only", int'(count_o), 10);
    tick(); check("R3 second tick decrements", int'(count_o), 9);
    step(); check("R3 no tick holds", int'(count_o), 9);
    // write coincident with tick
    wr_load_i = 1; wr_data_i = 16'd4; fast_tick_i = 1; step();
    check("R3 write beats tick", int'(count_o), 4);
    tick(); check("R3 arm after coincident write", int'(count_o), 4);
    tick(); check("R3 decrement after arm", int'(count_o), 3);

    // R4 free wrap
    wr(1); tick(); tick();
    check("R4 reach zero", int'(count_o), 0);
    tick();
    check("R4 wrap to FFFF", int'(count_o), 16'hFFFF);
    check("R6 irq set on underflow", int'(irq_o), 1);
    step(); check("R6 irq sticky", int'(irq_o), 1);
    eoi_i = 1; step(); check("R6 eoi clears", int'(irq_o), 0);

    // R10 / R5 prescale reload
    set_mode(1);
    check("R10 mode written", int'(mode_o), 1);
    check("R10 mode write keeps count", int'(count_o), 16'hFFFF);
    wr(2); tick(); tick(); tick();
    check("R5 at zero", int'(count_o), 0);
    tick();
    check("R5 reload written value", int'(count_o), 2);
    // underflow coincident with eoi
    tick(); tick();
    eoi_i = 1; tick();
    check("R6 set beats clear", int'(irq_o), 1);
    eoi_i = 1; step();
    check("R6 clear after", int'(irq_o), 0);

    // R9 prescale zero
    wr(0); tick();
    check("R9 arm keeps irq low", int'(irq_o), 0);
    tick(); check("R9 zero reload count", int'(count_o), 0);
    check("R9 irq each tick", int'(irq_o), 1);
    eoi_i = 1; step();
    tick(); check("R9 irq again", int'(irq_o), 1);

    // R7 source selection
    set_mode(0);
    wr(20); tick(); tick();
    check("R7 fast counts", int'(count_o), 19);
    tick_sel_i = 1;
    fast_tick_i = 1; div26_tick_i = 1; step();
    check("R7 unselected fast ignored", int'(count_o), 19);
    tick(); check("R7 slow counts", int'(count_o), 18);
    tick_sel_i = 0; div26_sel_i = 1;
    fast_tick_i = 1; slow_tick_i = 1; step();
    check("R7 fast ignored with div26", int'(count_o), 18);
    tick(); check("R7 div26 counts", int'(count_o), 17);
    div26_sel_i = 0;

    // R8 standby
    wr(7);
    standby_i = 1;
    tick(); tick(); tick();
    check("R8 standby holds", int'(count_o), 7);
    standby_i = 0;
    tick(); check("R8 arm kept across standby", int'(count_o), 7);
    tick(); check("R8 counts after standby", int'(count_o), 6);

    // mixed run against the model
    for (int i = 0; i < 3000; i++) begin
      fast_tick_i  = (i % 3) == 0;
      slow_tick_i  = (i % 13) == 0;
      div26_tick_i = (i % 4) == 1;
      tick_sel_i   = (i / 700) % 2 == 1;
      div26_sel_i  = (i / 450) % 2 == 1;
      standby_i    = (i % 97) < 6;
      eoi_i        = (i % 29) == 0;
      if ((i % 511) == 5) begin cfg_we_i = 1; cfg_mode_i = ~mode_o; end
      if ((i % 257) == 9) begin wr_load_i = 1; wr_data_i = 16'((i * 7) % 23); end
      step();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule